// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor that fetches, decodes and retires one instruction in every clock cycle. It executes seven instructions: register add, register subtract, OR with a zero-extended immediate, word load, word store, branch on equal and unconditional jump. Its parts are a program counter, a 32-entry register file with two read ports and one write port, an immediate extender, a three-function ALU, the steering multiplexers and a purely combinational decoder.

Instruction memory and data memory are small internal word arrays. Reads are combinational. The data array is written on the clock edge. The program is placed in the instruction array by hierarchical access before reset is released. The write activity of each retiring instruction is brought out on ports, so the effect of a program can be followed one cycle at a time.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high `rst` is high, `pc_o` becomes 0 at the next clock edge and both `rf_we_o` and `dm_we_o` stay low.
- R2: Instruction fields are op=[31:26], rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. When op is 000000, funct 100000 writes rs+rt into rd and funct 100010 writes rs-rt into rd (modulo 2^32). The PC then advances by 4.
- R3: Opcode 001101 writes rs OR {16'b0, imm[15:0]} into rt. The immediate is zero-extended even when imm[15] is 1.
- R4: Opcode 100011 loads the data word at byte address rs+sign_extend(imm) into rt.
- R5: Opcode 101011 writes register rt to the data word at byte address rs+sign_extend(imm). It asserts `dm_we_o` and never `rf_we_o`.
- R6: Opcode 000100 compares rs with rt by subtraction. When they are equal, the next PC is PC+4+(sign_extend(imm)<<2). Otherwise it is PC+4. Nothing is written.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00}. Nothing is written.
- R8: Register 0 always reads as zero. A write aimed at it has no lasting effect.
- R9: Any other opcode, and any R-type funct other than the two above, writes nothing and advances the PC by 4.
- R10: A register written by one instruction holds the new value for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register of the current instruction |
| rf_wdata_o | output | 32 | Value written to the destination register |
| dm_we_o | output | 1 | Data memory write enable of the current instruction |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (register rt) |

## Verification
Every result belongs to the cycle in which its instruction is current. The write ports and `pc_o` are combinational from the PC register, so they are settled at the falling edge that follows the edge which loaded that PC. Register-file and data-memory updates appear from the next falling edge onward, through the operands of later instructions. A reference model of the seven instructions runs the program ahead of the core and queues one expected record per retired instruction. A monitor pops one record at each falling edge after reset is released, so the PC sequence checks branch and jump timing with no slack. Final register values are brought out through store instructions.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN      = 32;
    localparam int REG_ABITS = 5;

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] OPC_JMP  = 6'b000010;
    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    opb_is_imm;
        logic    wb_from_mem;
        logic    reg_we;
        logic    mem_we;
        logic    is_beq;
        logic    is_jmp;
        logic    imm_signed;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] widen16(input logic [15:0] v, input logic signed_mode);
        return signed_mode ? {{(XLEN-16){v[15]}}, v} : {{(XLEN-16){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    logic is_reg, is_add, is_sub, is_ori, is_ld, is_st, is_br, is_j;

    always_comb begin
        is_reg = (opcode == OPC_REG);
        is_add = is_reg && (funct == FN_ADD);
        is_sub = is_reg && (funct == FN_SUB);
        is_ori = (opcode == OPC_ORI);
        is_ld  = (opcode == OPC_LOAD);
        is_st  = (opcode == OPC_STOR);
        is_br  = (opcode == OPC_BEQ);
        is_j   = (opcode == OPC_JMP);

        ctl             = '0;
        ctl.dst_is_rd   = is_add | is_sub;
        ctl.opb_is_imm  = is_ori | is_ld | is_st;
        ctl.wb_from_mem = is_ld;
        ctl.reg_we      = is_add | is_sub | is_ori | is_ld;
        ctl.mem_we      = is_st;
        ctl.is_beq      = is_br;
        ctl.is_jmp      = is_j;
        ctl.imm_signed  = is_ld | is_st;
        if (is_sub | is_br)
            ctl.alu_op = ALU_SUB;
        else if (is_ori)
            ctl.alu_op = ALU_OR;
        else
            ctl.alu_op = ALU_ADD;
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] ra_a,
    input  logic [$clog2(NREGS)-1:0] ra_b,
    output logic [WIDTH-1:0]         rd_a,
    output logic [WIDTH-1:0]         rd_b,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [WIDTH-1:0]         wd
);
    localparam int AW = $clog2(NREGS);

    logic [WIDTH-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && (wa != AW'(0))) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == AW'(0)) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == AW'(0)) ? '0 : regs_q[ra_b];

    a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (ra_a == AW'(0)) |-> (rd_a == '0));

    a_r10_write_seen: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != AW'(0))) |=> ((ra_a != $past(wa)) || (rd_a == $past(wd))));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] res,
    output logic             zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: res = opa - opb;
            ALU_OR:  res = opa | opb;
            default: res = opa + opb;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [XLEN-1:0]      pc_o,
    output logic                 rf_we_o,
    output logic [REG_ABITS-1:0] rf_waddr_o,
    output logic [XLEN-1:0]      rf_wdata_o,
    output logic                 dm_we_o,
    output logic [XLEN-1:0]      dm_addr_o,
    output logic [XLEN-1:0]      dm_wdata_o
);
    localparam int IA = $clog2(IMEM_WORDS);
    localparam int DA = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    end

    logic [XLEN-1:0] pc_q, pc_next, pc_seq, br_target, j_target;
    logic [XLEN-1:0] instr, imm_ext, opa, opb, alu_res, mem_word, wb_val;
    logic            alu_zero;
    ctrl_t           ctl;

    assign instr = imem_q[pc_q[IA+1:2]];

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    logic [REG_ABITS-1:0] dest;
    assign dest = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.NREGS(1 << REG_ABITS), .WIDTH(XLEN)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (opa),
        .rd_b (dm_wdata_o),
        .we   (rf_we_o),
        .wa   (dest),
        .wd   (wb_val)
    );

    assign imm_ext = widen16(instr[15:0], ctl.imm_signed);
    assign opb     = ctl.opb_is_imm ? imm_ext : dm_wdata_o;

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .opa  (opa),
        .opb  (opb),
        .op   (ctl.alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

    assign mem_word = dmem_q[alu_res[DA+1:2]];
    assign wb_val   = ctl.wb_from_mem ? mem_word : alu_res;

    always_ff @(posedge clk) begin
        if (dm_we_o) dmem_q[alu_res[DA+1:2]] <= dm_wdata_o;
    end

    assign pc_seq    = pc_q + XLEN'(4);
    assign br_target = pc_seq + {widen16(instr[15:0], 1'b1)[XLEN-3:0], 2'b00};
    assign j_target  = {pc_seq[XLEN-1:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.is_jmp)                pc_next = j_target;
        else if (ctl.is_beq && alu_zero) pc_next = br_target;
        else                           pc_next = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = ctl.reg_we & ~rst;
    assign rf_waddr_o = dest;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = ctl.mem_we & ~rst;
    assign dm_addr_o  = alu_res;

    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (!rf_we_o && !dm_we_o));

    a_r9_sequential_pc: assert property (@(posedge clk) disable iff (rst)
        (!ctl.is_jmp && !(ctl.is_beq && (opa == dm_wdata_o))) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    a_r6_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (ctl.is_beq && (opa == dm_wdata_o)) |=>
        (pc_q == $past(pc_q) + XLEN'(4) + $past({{(XLEN-18){instr[15]}}, instr[15:0], 2'b00})));

    a_r7_jump_low_bits: assert property (@(posedge clk) disable iff (rst)
        ctl.is_jmp |=> (pc_q[27:0] == $past({instr[25:0], 2'b00})));

    a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    localparam int NSTEPS = 60;
    localparam int PWORDS = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    always #10 clk = ~clk;

    sc_core uut (
        .clk(clk), .rst(rst), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        rwe;
        logic [4:0]  rwa;
        logic [31:0] rwd;
        logic        mwe;
        logic [31:0] mad;
        logic [31:0] mwd;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [31:0] prog  [PWORDS];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;
    int          last_wr = 0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int word);
        return {6'b000010, 26'(word)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model of one instruction; pushes the expected record.
    task automatic model_step();
        exp_t        e;
        logic [31:0] ins, a, b, sx, zx, nxt;
        int          rs, rt, rd;
        bit          known;
        ins = prog[m_pc[6:2]];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a  = (rs == 0) ? 32'd0 : m_reg[rs];
        b  = (rt == 0) ? 32'd0 : m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'd0, ins[15:0]};
        e.pc = m_pc; e.rwe = 0; e.rwa = 0; e.rwd = 0; e.mwe = 0; e.mad = 0; e.mwd = 0;
        nxt = m_pc + 4;
        known = 1'b1;
        e.req = "R2";
        case (ins[31:26])
            6'b000000: begin
                if (ins[5:0] == 6'b100000) begin e.rwe = 1; e.rwa = 5'(rd); e.rwd = a + b; end
                else if (ins[5:0] == 6'b100010) begin e.rwe = 1; e.rwa = 5'(rd); e.rwd = a - b; end
                else known = 1'b0;
            end
            6'b001101: begin e.req = "R3"; e.rwe = 1; e.rwa = 5'(rt); e.rwd = a | zx; end
            6'b100011: begin e.req = "R4"; e.rwe = 1; e.rwa = 5'(rt); e.rwd = m_mem[(a + sx) >> 2]; end
            6'b101011: begin e.req = "R5"; e.mwe = 1; e.mad = a + sx; e.mwd = b; end
            6'b000100: begin e.req = "R6"; if (a == b) nxt = m_pc + 4 + (sx << 2); end
            6'b000010: begin e.req = "R7"; nxt = {nxt[31:28], ins[25:0], 2'b00}; end
            default:   known = 1'b0;
        endcase
        if (!known) e.req = "R9";
        else if (e.rwe && e.rwa == 5'd0) e.req = "R8";
        else if (last_wr != 0 && (rs == last_wr || rt == last_wr)) e.req = "R10";
        else if (rs == 0 && e.rwe && ins[31:26] == 6'b000000) e.req = "R8";
        last_wr = 0;
        if (e.rwe) begin
            if (e.rwa != 0) begin m_reg[e.rwa] = e.rwd; last_wr = int'(e.rwa); end
        end
        if (e.mwe) m_mem[e.mad >> 2] = e.mwd;
        m_pc = nxt;
        exp_q.push_back(e);
    endtask

    task automatic load_program();
        prog[0]  = enc_i(6'b001101, 0, 1, 16'h8001);   // ori, imm[15]=1
        prog[1]  = enc_i(6'b001101, 0, 2, 16'h0003);
        prog[2]  = enc_r(1, 2, 3, 6'b100000);          // add, back-to-back use
        prog[3]  = enc_r(2, 1, 4, 6'b100010);          // sub, wraps negative
        prog[4]  = enc_i(6'b001101, 0, 0, 16'h1234);   // write aimed at r0
        prog[5]  = enc_r(0, 2, 5, 6'b100000);          // r0 must read zero
        prog[6]  = enc_i(6'b001101, 0, 6, 16'h0040);
        prog[7]  = enc_i(6'b101011, 6, 4, 16'hFFFC);   // store, negative offset
        prog[8]  = enc_i(6'b100011, 6, 7, 16'hFFFC);   // load it back
        prog[9]  = enc_r(7, 0, 8, 6'b100000);
        prog[10] = enc_i(6'b000100, 1, 2, 16'h0005);   // beq not taken
        prog[11] = enc_i(6'b000100, 7, 4, 16'h0002);   // beq taken to 14
        prog[12] = enc_i(6'b001101, 0, 9, 16'hDEAD);
        prog[13] = enc_i(6'b001101, 0, 9, 16'hBEEF);
        prog[14] = {6'b111111, 5'd1, 5'd10, 16'h0001}; // unknown opcode
        prog[15] = enc_r(1, 2, 11, 6'b100101);         // unknown funct
        prog[16] = enc_j(20);
        prog[17] = enc_i(6'b001101, 0, 12, 16'h0001);
        prog[18] = enc_i(6'b001101, 0, 12, 16'h0002);
        prog[19] = enc_i(6'b001101, 0, 12, 16'h0003);
        prog[20] = enc_i(6'b101011, 0, 5, 16'h0000);
        prog[21] = enc_i(6'b001101, 0, 13, 16'h0001);
        prog[22] = enc_i(6'b001101, 0, 14, 16'h0003);
        prog[23] = enc_r(14, 13, 14, 6'b100010);       // loop body
        prog[24] = enc_i(6'b000100, 14, 0, 16'h0001);  // exit when zero
        prog[25] = enc_j(23);                          // backward jump
        prog[26] = enc_i(6'b101011, 0, 8, 16'h0008);
        prog[27] = enc_j(27);                          // park
        for (int i = 0; i < PWORDS; i++) uut.imem_q[i] = prog[i];
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        m_pc = '0;
    endtask

    // Driver
    initial begin
        #1;
        load_program();
        for (int i = 0; i < NSTEPS; i++) model_step();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'd0);
        check("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        check("R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);
        @(posedge clk);
        #2 rst = 1'b0;
    end

    // Monitor: one record per instruction, at each falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.req, "pc", pc_o, e.pc);
                check(e.req, "rf_we", {31'd0, rf_we_o}, {31'd0, e.rwe});
                if (e.rwe) begin
                    check(e.req, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, e.rwa});
                    check(e.req, "rf_wdata", rf_wdata_o, e.rwd);
                end
                check(e.req, "dm_we", {31'd0, dm_we_o}, {31'd0, e.mwe});
                if (e.mwe) begin
                    check(e.req, "dm_addr", dm_addr_o, e.mad);
                    check(e.req, "dm_wdata", dm_wdata_o, e.mwd);
                end
                if (exp_q.size() == 0) done = 1'b1;
            end
        end
    end

    // Completion and watchdog
    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule